// File: doc/BRIEF.md
# Bus Write Monitor Logger

This block watches write transactions on a memory bus. The bus has one core requester and four DMA requesters, and each beat carries a requester source identifier. For each beat the block decides whether the write should be logged. A beat qualifies only if all of the following hold:

- monitoring is switched on;
- the access size is one the current mode accepts;
- the requester's enable bit for that source identifier is set;
- the address falls inside a programmed window;
- every data byte that is not masked out equals the matching byte of a trigger pattern.

Each qualifying write produces a one-word log record that holds the captured bus address. The block emits the record together with the memory address where it should be stored. Those store addresses step through a ring region that software programs. The ring pointer either wraps back to the start of the region, which sets a sticky flag, or halts at the end, depending on the loop setting. A small word-indexed register port configures the block, reports the pointer and flag, and accepts two one-shot commands: reload the pointer, and clear the flag.

Top module: `bus_write_logger`

## Requirements
- R1: After reset the control register (index 0) reads 0x10, which means loop mode on and every mode bit off. The pointer (index 7) and the status register (index 9) read 0, and logValid is low.
- R2: Control bit 0 enables monitoring. While it is 0, or when busWrite is 0, no record is produced.
- R3: busSize codes are 0 for a byte, 1 for a halfword and 2 for a word; code 3 is never logged. A size is accepted only when its control bit is set: bit 3 for byte, bit 2 for halfword, bit 1 for word.
- R4: busPort 0 is the core and ports 1 to 4 are DMA; port values 5 to 7 are never logged. Enable register 16+p holds an 8-bit mask for port p, and bit busSrc of that mask must be 1 for the beat to be logged.
- R5: A beat is logged only if busAddr is at least the window low bound (index 3) and at most the window high bound (index 4). Both bounds are inclusive.
- R6: Index 1 holds the trigger pattern and index 2 holds a 4-bit byte mask. When mask bit i is 1, data bits 8i+7..8i are left out of the comparison. Every byte that is not masked must equal the pattern byte.
- R7: One cycle after a qualifying beat, logValid is 1, logAddr equals the pointer value before the update, and logData equals the beat's busAddr. The pointer then advances by 4.
- R8: In loop mode (control bit 4), a record whose next address would equal the ring end (index 6) sends the pointer back to the ring start (index 5) and sets status bit 0.
- R9: With loop mode off, the pointer stops at the ring end, and no record is produced while the pointer equals the ring end.
- R10: Writing 1 to bit 0 of the command register (index 8) loads the pointer from the ring start. A beat in the same cycle produces no record.
- R11: Writing 1 to bit 1 of the command register clears status bit 0. The clear wins over a wrap in the same cycle.
- R12: Configuration registers read back the value last written. The command register reads 0, and status bit 0 shows the sticky wrap flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register word index |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational) |
| busValid | input | 1 | Bus beat present |
| busWrite | input | 1 | Beat is a write |
| busPort | input | 3 | Requester port: 0 core, 1 to 4 DMA |
| busSrc | input | 3 | Source identifier within the port |
| busSize | input | 2 | Access size code |
| busAddr | input | 32 | Beat address |
| busData | input | 32 | Beat write data |
| logValid | output | 1 | Log record valid |
| logAddr | output | 32 | Memory address for the record |
| logData | output | 32 | Record content: the captured address |

## Verification
The bound checker watches several properties on every cycle:
- each record lands at the pointer value from the cycle before;
- the pointer holds still unless a record or a reload occurred;
- the flag rises only together with a wrap back to the ring start;
- a reload and a clear take effect in the next cycle;
- with loop mode off, no record is produced at the ring end.

Only the bench scenarios can show the filter decisions themselves. These are the size and mode pairing, the per-port source enables, the inclusive window edges and the byte-masked match. The bench sweeps each of these and compares the results against its own arithmetic model, alongside the register readback.

// File: rtl/bwl_pkg.sv
`timescale 1ns/1ps
package bwl_pkg;

  localparam int RIDX_W = 5;

  localparam logic [RIDX_W-1:0] REG_CTRL     = 5'd0;
  localparam logic [RIDX_W-1:0] REG_PATTERN  = 5'd1;
  localparam logic [RIDX_W-1:0] REG_MASK     = 5'd2;
  localparam logic [RIDX_W-1:0] REG_WIN_LO   = 5'd3;
  localparam logic [RIDX_W-1:0] REG_WIN_HI   = 5'd4;
  localparam logic [RIDX_W-1:0] REG_RING_BEG = 5'd5;
  localparam logic [RIDX_W-1:0] REG_RING_END = 5'd6;
  localparam logic [RIDX_W-1:0] REG_PTR      = 5'd7;
  localparam logic [RIDX_W-1:0] REG_CMD      = 5'd8;
  localparam logic [RIDX_W-1:0] REG_STATUS   = 5'd9;
  localparam logic [RIDX_W-1:0] REG_ENA_BASE = 5'd16;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } bwl_size_e;

  // control to datapath strobes
  typedef struct packed {
    logic logReq;     // beat passed every filter
    logic reload;     // pointer reload command
    logic clearFull;  // flag clear command
  } bwl_strobe_t;

endpackage

// File: rtl/bwl_ctrl.sv
`timescale 1ns/1ps
module bwl_ctrl
  import bwl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 32,
  parameter int N_PORT = 5,
  parameter int PORT_W = 3,
  parameter int SRC_W  = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [RIDX_W-1:0]    regAddr,
  input  logic [REG_W-1:0]     regWdata,
  output logic [REG_W-1:0]     regRdata,
  input  logic                 busValid,
  input  logic                 busWrite,
  input  logic [PORT_W-1:0]    busPort,
  input  logic [SRC_W-1:0]     busSrc,
  input  logic [1:0]           busSize,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [DATA_W-1:0]    busData,
  input  logic [ADDR_W-1:0]    curPtr,
  input  logic                 fullFlag,
  output bwl_strobe_t          strb,
  output logic                 loopEn,
  output logic [ADDR_W-1:0]    ringStart,
  output logic [ADDR_W-1:0]    ringEnd
);

  localparam int LANES = DATA_W / 8;
  localparam int SRC_N = 1 << SRC_W;

  logic [3:0]              modeReg;
  logic                    loopReg;
  logic [DATA_W-1:0]       patReg;
  logic [LANES-1:0]        maskReg;
  logic [ADDR_W-1:0]       winLo, winHi, ringBeg, ringFin;
  logic [SRC_N-1:0]        enaReg [N_PORT];

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= '0;
      loopReg <= 1'b1;
      patReg  <= '0;
      maskReg <= '0;
      winLo   <= '0;
      winHi   <= '0;
      ringBeg <= '0;
      ringFin <= '0;
    end else if (regWrEn) begin
      case (regAddr)
        REG_CTRL:     begin modeReg <= regWdata[3:0]; loopReg <= regWdata[4]; end
        REG_PATTERN:  patReg  <= regWdata[DATA_W-1:0];
        REG_MASK:     maskReg <= regWdata[LANES-1:0];
        REG_WIN_LO:   winLo   <= regWdata[ADDR_W-1:0];
        REG_WIN_HI:   winHi   <= regWdata[ADDR_W-1:0];
        REG_RING_BEG: ringBeg <= regWdata[ADDR_W-1:0];
        REG_RING_END: ringFin <= regWdata[ADDR_W-1:0];
        default: ;
      endcase
    end
  end

  // per-port source enables
  for (genvar p = 0; p < N_PORT; p++) begin : gEna
    localparam logic [RIDX_W-1:0] IDX = REG_ENA_BASE + RIDX_W'(p);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                          enaReg[p] <= '0;
      else if (regWrEn && regAddr == IDX) enaReg[p] <= regWdata[SRC_N-1:0];
    end
  end

  // filter: size
  logic sizeOk;
  always_comb begin
    case (bwl_size_e'(busSize))
      SZ_BYTE: sizeOk = modeReg[3];
      SZ_HALF: sizeOk = modeReg[2];
      SZ_WORD: sizeOk = modeReg[1];
      default: sizeOk = 1'b0;
    endcase
  end

  // filter: requester enable
  logic srcOk;
  always_comb begin
    srcOk = 1'b0;
    for (int p = 0; p < N_PORT; p++)
      if (busPort == PORT_W'(p)) srcOk = enaReg[p][busSrc];
  end

  // filter: masked data match per byte lane
  logic [LANES-1:0] laneOk;
  for (genvar b = 0; b < LANES; b++) begin : gLane
    assign laneOk[b] = maskReg[b] | (busData[8*b +: 8] == patReg[8*b +: 8]);
  end

  logic winOk;
  assign winOk = (busAddr >= winLo) && (busAddr <= winHi);

  logic cmdWr;
  assign cmdWr = regWrEn && (regAddr == REG_CMD);

  assign strb.logReq    = busValid & busWrite & modeReg[0] & sizeOk & srcOk & winOk & (&laneOk);
  assign strb.reload    = cmdWr & regWdata[0];
  assign strb.clearFull = cmdWr & regWdata[1];

  assign loopEn    = loopReg;
  assign ringStart = ringBeg;
  assign ringEnd   = ringFin;

  // readback
  always_comb begin
    regRdata = '0;
    case (regAddr)
      REG_CTRL:     regRdata = REG_W'({loopReg, modeReg});
      REG_PATTERN:  regRdata = REG_W'(patReg);
      REG_MASK:     regRdata = REG_W'(maskReg);
      REG_WIN_LO:   regRdata = REG_W'(winLo);
      REG_WIN_HI:   regRdata = REG_W'(winHi);
      REG_RING_BEG: regRdata = REG_W'(ringBeg);
      REG_RING_END: regRdata = REG_W'(ringFin);
      REG_PTR:      regRdata = REG_W'(curPtr);
      REG_STATUS:   regRdata = REG_W'(fullFlag);
      default: ;
    endcase
    for (int p = 0; p < N_PORT; p++)
      if (regAddr == REG_ENA_BASE + RIDX_W'(p)) regRdata = REG_W'(enaReg[p]);
  end

endmodule

// File: rtl/bwl_datapath.sv
`timescale 1ns/1ps
module bwl_datapath
  import bwl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  bwl_strobe_t        strb,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               loopEn,
  input  logic [ADDR_W-1:0]  ringStart,
  input  logic [ADDR_W-1:0]  ringEnd,
  output logic [ADDR_W-1:0]  curPtr,
  output logic               fullFlag,
  output logic               logValid,
  output logic [ADDR_W-1:0]  logAddr,
  output logic [ADDR_W-1:0]  logData
);

  localparam int REC_STEP = DATA_W / 8;

  logic [ADDR_W-1:0] ptrInc;
  logic              doLog, wrapNow;

  assign ptrInc  = curPtr + ADDR_W'(REC_STEP);
  assign doLog   = strb.logReq && !strb.reload && (loopEn || (curPtr != ringEnd));
  assign wrapNow = doLog && loopEn && (ptrInc == ringEnd);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curPtr   <= '0;
      fullFlag <= 1'b0;
      logValid <= 1'b0;
      logAddr  <= '0;
      logData  <= '0;
    end else begin
      logValid <= doLog;
      if (doLog) begin
        logAddr <= curPtr;
        logData <= busAddr;
      end
      if (strb.reload)  curPtr <= ringStart;
      else if (wrapNow) curPtr <= ringStart;
      else if (doLog)   curPtr <= ptrInc;
      if (strb.clearFull) fullFlag <= 1'b0;
      else if (wrapNow)   fullFlag <= 1'b1;
    end
  end

endmodule

// File: rtl/bus_write_logger.sv
`timescale 1ns/1ps
module bus_write_logger
  import bwl_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int REG_W  = 32,
  parameter int N_PORT = 5,
  parameter int PORT_W = 3,
  parameter int SRC_W  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [RIDX_W-1:0]  regAddr,
  input  logic [REG_W-1:0]   regWdata,
  output logic [REG_W-1:0]   regRdata,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic [PORT_W-1:0]  busPort,
  input  logic [SRC_W-1:0]   busSrc,
  input  logic [1:0]         busSize,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [DATA_W-1:0]  busData,
  output logic               logValid,
  output logic [ADDR_W-1:0]  logAddr,
  output logic [ADDR_W-1:0]  logData
);

  bwl_strobe_t       strb;
  logic              loopEn, fullFlag;
  logic [ADDR_W-1:0] ringStart, ringEnd, curPtr;

  bwl_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W),
    .N_PORT(N_PORT), .PORT_W(PORT_W), .SRC_W(SRC_W)
  ) uCtrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .busValid(busValid), .busWrite(busWrite), .busPort(busPort), .busSrc(busSrc),
    .busSize(busSize), .busAddr(busAddr), .busData(busData),
    .curPtr(curPtr), .fullFlag(fullFlag),
    .strb(strb), .loopEn(loopEn), .ringStart(ringStart), .ringEnd(ringEnd)
  );

  bwl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .busAddr(busAddr),
    .loopEn(loopEn), .ringStart(ringStart), .ringEnd(ringEnd),
    .curPtr(curPtr), .fullFlag(fullFlag),
    .logValid(logValid), .logAddr(logAddr), .logData(logData)
  );

endmodule

// File: rtl/bwl_checker.sv
`timescale 1ns/1ps
module bwl_checker
  import bwl_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input bwl_strobe_t        strb,
  input logic               loopEn,
  input logic [ADDR_W-1:0]  ringStart,
  input logic [ADDR_W-1:0]  ringEnd,
  input logic [ADDR_W-1:0]  curPtr,
  input logic               fullFlag,
  input logic               logValid,
  input logic [ADDR_W-1:0]  logAddr
);

  assert_rec_addr_R7: assert property (@(posedge clk) disable iff (!rstN)
    logValid |-> logAddr == $past(curPtr));

  assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(strb.logReq) && !$past(strb.reload)) |-> curPtr == $past(curPtr));

  assert_wrap_full_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fullFlag) |-> (logValid && curPtr == $past(ringStart)));

  assert_stop_end_R9: assert property (@(posedge clk) disable iff (!rstN)
    (logValid && !$past(loopEn)) |-> $past(curPtr) != $past(ringEnd));

  assert_reload_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.reload) |-> (curPtr == $past(ringStart) && !logValid));

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.clearFull) |-> !fullFlag);

endmodule

bind bus_write_logger bwl_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .strb(strb), .loopEn(loopEn),
  .ringStart(ringStart), .ringEnd(ringEnd), .curPtr(curPtr),
  .fullFlag(fullFlag), .logValid(logValid), .logAddr(logAddr)
);

// File: tb/tb_bus_write_logger.sv
`timescale 1ns/1ps
module tb_bus_write_logger;

  logic        clk = 0, rstN = 0;
  logic        regWrEn = 0;
  logic [4:0]  regAddr = 0;
  logic [31:0] regWdata = 0, regRdata;
  logic        busValid = 0, busWrite = 0;
  logic [2:0]  busPort = 0, busSrc = 0;
  logic [1:0]  busSize = 0;
  logic [31:0] busAddr = 0, busData = 0;
  logic        logValid;
  logic [31:0] logAddr, logData;

  always #5 clk = ~clk;

  bus_write_logger dut (.*);

  int checks = 0, failures = 0;
  bit done = 0;

  // bench model of configuration and state
  logic [3:0]  mMode = 0;
  logic        mLoop = 1;
  logic [7:0]  mEna [5];
  logic [31:0] mPat = 0, mLo = 0, mHi = 0, mStart = 0, mEnd = 0, mPtr = 0;
  logic [3:0]  mMask = 0;
  logic        mFull = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 0;
    case (a)
      5'd0: begin mMode = d[3:0]; mLoop = d[4]; end
      5'd1: mPat = d;
      5'd2: mMask = d[3:0];
      5'd3: mLo = d;
      5'd4: mHi = d;
      5'd5: mStart = d;
      5'd6: mEnd = d;
      5'd8: begin if (d[0]) mPtr = mStart; if (d[1]) mFull = 0; end
      default: if (a >= 16 && a < 21) mEna[a-16] = d[7:0];
    endcase
  endtask

  task automatic rreg(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    regAddr = a;
    #1 v = regRdata;
  endtask

  function automatic bit qual(input logic [2:0] p, input logic [2:0] s, input logic [1:0] sz,
                              input logic [31:0] a, input logic [31:0] d, input logic w);
    bit szOk, pOk, dm;
    szOk = (sz == 0 && mMode[3]) || (sz == 1 && mMode[2]) || (sz == 2 && mMode[1]);
    pOk  = (p < 5) ? mEna[p][s] : 1'b0;
    dm = 1;
    for (int i = 0; i < 4; i++)
      if (!mMask[i] && d[8*i +: 8] != mPat[8*i +: 8]) dm = 0;
    return w && mMode[0] && szOk && pOk && (a >= mLo) && (a <= mHi) && dm;
  endfunction

  task automatic beat(input string tag, input logic [2:0] p, input logic [2:0] s,
                      input logic [1:0] sz, input logic [31:0] a, input logic [31:0] d,
                      input logic w, input logic [1:0] cmd);
    bit hit, wrap;
    logic [31:0] expAddr;
    @(negedge clk);
    busValid = 1; busWrite = w; busPort = p; busSrc = s; busSize = sz;
    busAddr = a; busData = d;
    if (cmd != 0) begin regWrEn = 1; regAddr = 5'd8; regWdata = {30'd0, cmd}; end
    hit = qual(p, s, sz, a, d, w) && (mLoop || mPtr != mEnd) && !cmd[0];
    expAddr = mPtr; wrap = 0;
    if (cmd[0]) mPtr = mStart;
    else if (hit) begin
      if (mLoop && mPtr + 4 == mEnd) begin mPtr = mStart; wrap = 1; end
      else mPtr = mPtr + 4;
    end
    if (cmd[1]) mFull = 0; else if (wrap) mFull = 1;
    @(negedge clk);
    busValid = 0; busWrite = 0; regWrEn = 0;
    chk(logValid == hit, {tag, " logValid"}, 32'(logValid), 32'(hit));
    if (hit && logValid) begin
      chk(logAddr == expAddr, "R7 logAddr", logAddr, expAddr);
      chk(logData == a, "R7 logData", logData, a);
    end
  endtask

  task automatic chkState(input string tag);
    logic [31:0] v;
    rreg(5'd7, v); chk(v == mPtr, {tag, " pointer"}, v, mPtr);
    rreg(5'd9, v); chk(v == 32'(mFull), {tag, " status"}, v, 32'(mFull));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog (all requirements) actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int p = 0; p < 5; p++) mEna[p] = 0;
    repeat (4) @(negedge clk);
    rstN = 1;

    // R1 reset state
    chk(logValid == 0, "R1 logValid", 32'(logValid), 0);
    rreg(5'd0, v); chk(v == 32'h10, "R1 control", v, 32'h10);
    rreg(5'd7, v); chk(v == 0, "R1 pointer", v, 0);
    rreg(5'd9, v); chk(v == 0, "R1 status", v, 0);
    rreg(5'd8, v); chk(v == 0, "R12 command reads zero", v, 0);

    // base configuration
    wreg(5'd0, 32'h1F);
    for (int p = 0; p < 5; p++) wreg(5'(16 + p), 32'hFF);
    wreg(5'd2, 32'hF);
    wreg(5'd3, 32'h1000);
    wreg(5'd4, 32'h1FFF);
    wreg(5'd5, 32'h100);
    wreg(5'd6, 32'h200);
    wreg(5'd8, 32'h1);
    chkState("R10 reload");

    // R3 size x mode sweep
    for (int m = 0; m < 8; m++)
      for (int s = 0; s < 4; s++) begin
        wreg(5'd0, {27'd0, 1'b1, 3'(m), 1'b1});
        beat("R3", 0, 0, 2'(s), 32'h1000 + 32'(4 * s), 32'h0, 1, 0);
      end
    chkState("R7");

    // R2 monitor gate and reads
    wreg(5'd0, 32'h1E);
    for (int s = 0; s < 4; s++) beat("R2 monitor off", 1, 1, 2'(s), 32'h1100, 0, 1, 0);
    wreg(5'd0, 32'h1F);
    for (int s = 0; s < 3; s++) beat("R2 read beat", 1, 1, 2'(s), 32'h1100, 0, 0, 0);

    // R4 port x source sweep with rotated enables
    for (int p = 0; p < 5; p++) wreg(5'(16 + p), 32'((8'hA5 >> p) | (8'hA5 << (8 - p))));
    wreg(5'd8, 32'h1);
    for (int p = 0; p < 8; p++)
      for (int s = 0; s < 8; s++) beat("R4", 3'(p), 3'(s), 2, 32'h1200, 0, 1, 0);
    chkState("R4");
    for (int p = 0; p < 5; p++) begin
      rreg(5'(16 + p), v); chk(v == 32'(mEna[p]), "R12 enable readback", v, 32'(mEna[p]));
      wreg(5'(16 + p), 32'hFF);
    end

    // R5 window edges
    beat("R5 below low", 0, 0, 2, 32'h0FFF, 0, 1, 0);
    beat("R5 at low",    0, 0, 2, 32'h1000, 0, 1, 0);
    beat("R5 at high",   0, 0, 2, 32'h1FFF, 0, 1, 0);
    beat("R5 above high",0, 0, 2, 32'h2000, 0, 1, 0);
    beat("R5 zero",      0, 0, 2, 32'h0, 0, 1, 0);
    beat("R5 top",       0, 0, 2, 32'hFFFF_FFFF, 0, 1, 0);

    // R6 byte mask x differing byte sweep
    wreg(5'd1, 32'h1122_3344);
    for (int mk = 0; mk < 16; mk++) begin
      wreg(5'd2, 32'(mk));
      for (int k = 0; k < 5; k++)
        beat("R6", 2, 3, 2, 32'h1300, (k < 4) ? (32'h1122_3344 ^ (32'hFF << (8 * k))) : 32'h1122_3344, 1, 0);
    end
    wreg(5'd2, 32'hF);

    // R8 wrap with a four-slot ring
    wreg(5'd6, 32'h110);
    wreg(5'd8, 32'h3);
    for (int i = 0; i < 4; i++) beat("R8", 0, 0, 2, 32'h1400 + 32'(i), 0, 1, 0);
    chkState("R8");
    beat("R8 after wrap", 0, 0, 2, 32'h1404, 0, 1, 0);

    // R11 clear, and clear against a wrap in the same cycle
    wreg(5'd8, 32'h2);
    chkState("R11 clear");
    wreg(5'd8, 32'h1);
    for (int i = 0; i < 3; i++) beat("R11", 0, 0, 2, 32'h1500, 0, 1, 0);
    beat("R11 clear vs wrap", 0, 0, 2, 32'h1504, 0, 1, 2'b10);
    chkState("R11 priority");

    // R10 reload against a beat in the same cycle
    beat("R7 advance", 0, 0, 2, 32'h1600, 0, 1, 0);
    beat("R10 reload vs beat", 0, 0, 2, 32'h1604, 0, 1, 2'b01);
    chkState("R10 priority");

    // R9 stop mode
    wreg(5'd0, 32'h0F);
    wreg(5'd8, 32'h3);
    for (int i = 0; i < 6; i++) beat("R9", 4, 7, 2, 32'h1700 + 32'(4 * i), 0, 1, 0);
    chkState("R9");

    // R12 readback
    rreg(5'd0, v); chk(v == 32'h0F, "R12 control", v, 32'h0F);
    rreg(5'd1, v); chk(v == mPat, "R12 pattern", v, mPat);
    rreg(5'd2, v); chk(v == 32'hF, "R12 mask", v, 32'hF);
    rreg(5'd3, v); chk(v == mLo, "R12 window low", v, mLo);
    rreg(5'd4, v); chk(v == mHi, "R12 window high", v, mHi);
    rreg(5'd5, v); chk(v == mStart, "R12 ring start", v, mStart);
    rreg(5'd6, v); chk(v == mEnd, "R12 ring end", v, mEnd);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule